// File: doc/BRIEF.md
# Byte-Serial Register Move Sequencer

This block holds six 16-bit machine registers and carries out register-to-register copy and swap operations over an internal datapath that is one byte wide. Each operation is started by a one-cycle strobe together with a mode bit (copy or swap) and a selector byte. The selector byte's high nibble names the first register and its low nibble names the second. Every move is a full 16-bit move, whichever registers are named. Each 16-bit move takes two cycles, one per byte, and passes through a hidden staging register.

A copy takes six cycles and a swap takes eight. The first two cycles stand for fetching the opcode and the selector byte into the instruction register; the selector fields are captured with the strobe. A busy flag covers the whole sequence, and a one-cycle done pulse marks its end. All six registers are visible on read ports. The upper byte of the page/flags register also sets the base of a 256-byte direct-access window.

The surrounding core loads results into the registers through a single write port. That port is accepted only while the sequencer is idle. It can also write either 8-bit half of the accumulator pair on its own.

Top module: `regxfer_seq`

## Requirements
- R1: After reset, all six registers and the staging register are zero, busy is low and done is low.
- R2: For a copy (`op_exg`=0), selector high nibble = source and low nibble = destination. Codes: 0=accumulator pair, 1=X, 2=Y, 3=U, 4=S, 6=page/flags. When start is taken at edge t, busy is high after edges t..t+5. At edge t+6 the destination holds the source's old value, the source is unchanged, busy falls and done rises.
- R3: For a swap (`op_exg`=1), the two named registers exchange contents at edge t+8. Busy is high after edges t..t+7.
- R4: Each 16-bit move writes the low byte first and the high byte one cycle later. During a copy, after edge t+5 the destination's low byte holds the new value and its high byte still holds the old one.
- R5: If either selector nibble is a code outside the list in R2, no register changes. The sequence still runs its full 6 or 8 cycles and raises done.
- R6: A start strobe while busy is ignored. The running operation completes unchanged and keeps its length.
- R7: Done is high for exactly one cycle, in the first cycle after busy falls.
- R8: `dp_base` equals {page/flags[15:8], 8'h00}.
- R9: The write port (`wr_en`, `wr_sel`, `wr_data`) writes a register at the next edge, using the R2 codes. Code 8 writes `wr_data[7:0]` into the accumulator's high half (A); code 9 writes it into the low half (B). The write is ignored while busy or when start is high in the same cycle.
- R10: Any register, including the same register on both sides, can be copied or swapped. A self-move leaves the value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken when idle) |
| op_exg | input | 1 | 0 = copy, 1 = swap |
| post | input | 8 | Selector byte: [7:4] first register, [3:0] second register |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Write target code |
| wr_data | input | 16 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| rd_d | output | 16 | Accumulator pair (A high, B low) |
| rd_x | output | 16 | X pointer |
| rd_y | output | 16 | Y pointer |
| rd_u | output | 16 | U pointer |
| rd_s | output | 16 | S pointer |
| rd_dpcc | output | 16 | Page byte high, flags byte low |
| dp_base | output | 16 | Direct-window base address |

## Verification
Write-port results are due one edge after the strobe. Operation results, the fall of busy and the done pulse are all due exactly 6 (copy) or 8 (swap) edges after the edge that takes start. The byte-order check of R4 is due one edge before that end.

The bench drives inputs and samples outputs on falling edges. It counts the falling edges on which busy is high, requires that count to be exactly 6 or 8, and checks done and every register on the first falling edge with busy low. For R4 it samples the destination on the sixth busy falling edge of a copy, where only the low byte has moved.

// File: rtl/regxfer_seq.sv
module regxfer_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         op_exg,
  input  logic [7:0]   post,
  input  logic         wr_en,
  input  logic [3:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] rd_d,
  output logic [W-1:0] rd_x,
  output logic [W-1:0] rd_y,
  output logic [W-1:0] rd_u,
  output logic [W-1:0] rd_s,
  output logic [W-1:0] rd_dpcc,
  output logic [W-1:0] dp_base
);
  localparam int H = W / 2;
  localparam logic [3:0] CPY_LEN = 4'd6;
  localparam logic [3:0] SWP_LEN = 4'd8;
  localparam logic [2:0] NONE = 3'd7;

  logic [W-1:0] rf [6];
  logic [W-1:0] tmp;
  logic [15:0]  ir;
  logic [3:0]   cyc;
  logic [2:0]   s1, s2, ws;
  logic         mode, ok;
  logic [3:0]   last;

  function automatic logic [2:0] slot_of(input logic [3:0] c);
    case (c)
      4'd0: slot_of = 3'd0;
      4'd1: slot_of = 3'd1;
      4'd2: slot_of = 3'd2;
      4'd3: slot_of = 3'd3;
      4'd4: slot_of = 3'd4;
      4'd6: slot_of = 3'd5;
      default: slot_of = NONE;
    endcase
  endfunction

  assign mode = ir[8];
  assign s1   = slot_of(ir[7:4]);
  assign s2   = slot_of(ir[3:0]);
  assign ws   = slot_of(wr_sel);
  assign ok   = (s1 != NONE) && (s2 != NONE);
  assign last = mode ? SWP_LEN : CPY_LEN;
  assign busy = (cyc != 4'd0);

  assign rd_d    = rf[0];
  assign rd_x    = rf[1];
  assign rd_y    = rf[2];
  assign rd_u    = rf[3];
  assign rd_s    = rf[4];
  assign rd_dpcc = rf[5];
  assign dp_base = {rf[5][W-1:H], {H{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 6; i++) rf[i] <= '0;
      tmp  <= '0;
      ir   <= '0;
      cyc  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          ir  <= {7'd0, op_exg, post};
          cyc <= 4'd1;
        end else if (wr_en) begin
          if (wr_sel == 4'd8)      rf[0][W-1:H] <= wr_data[H-1:0];
          else if (wr_sel == 4'd9) rf[0][H-1:0] <= wr_data[H-1:0];
          else if (ws != NONE)     rf[ws] <= wr_data;
        end
      end else begin
        cyc <= cyc + 4'd1;
        if (ok) begin
          case (cyc)
            4'd3: tmp[H-1:0] <= rf[s1][H-1:0];
            4'd4: tmp[W-1:H] <= rf[s1][W-1:H];
            4'd5: if (mode) rf[s1][H-1:0] <= rf[s2][H-1:0];
                  else      rf[s2][H-1:0] <= tmp[H-1:0];
            4'd6: if (mode) rf[s1][W-1:H] <= rf[s2][W-1:H];
                  else      rf[s2][W-1:H] <= tmp[W-1:H];
            4'd7: rf[s2][H-1:0] <= tmp[H-1:0];
            4'd8: rf[s2][W-1:H] <= tmp[W-1:H];
            default: ;
          endcase
        end
        if (cyc == last) begin
          cyc  <= 4'd0;
          done <= 1'b1;
        end
      end
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R2, R3
  seq_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cyc) == (mode ? SWP_LEN : CPY_LEN)));

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && cyc != last) |=> (cyc == $past(cyc) + 4'd1));

  // R5
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ok) |=> $stable({rd_d, rd_x, rd_y, rd_u, rd_s, rd_dpcc}));

  // R9
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && (cyc < 4'd5)) |=> $stable({rd_d, rd_x, rd_y, rd_u, rd_s, rd_dpcc}));
endmodule

// File: tb/regxfer_seq_bench.sv
module regxfer_seq_bench;
  logic clk = 0, rst_n = 0, start = 0, op_exg = 0, wr_en = 0;
  logic [7:0] post = 0;
  logic [3:0] wr_sel = 0;
  logic [15:0] wr_data = 0;
  logic busy, done;
  logic [15:0] rd_d, rd_x, rd_y, rd_u, rd_s, rd_dpcc, dp_base;
  int tests = 0, fails = 0;
  bit finished = 0;
  logic [15:0] m [6];

  regxfer_seq u_regxfer_seq (.*);

  always #5 clk = ~clk;

  localparam int NV = 9;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'h12}, {1'b0, 8'h06}, {1'b1, 8'h14}, {1'b1, 8'h03},
    {1'b0, 8'h51}, {1'b1, 8'h17}, {1'b1, 8'h60}, {1'b0, 8'h44},
    {1'b1, 8'h33}};

  function automatic int slot(input logic [3:0] c);
    case (c)
      4'd0: return 0; 4'd1: return 1; 4'd2: return 2;
      4'd3: return 3; 4'd4: return 4; 4'd6: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] rdp(input int k);
    case (k)
      0: return rd_d; 1: return rd_x; 2: return rd_y;
      3: return rd_u; 4: return rd_s; default: return rd_dpcc;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int k = 0; k < 6; k++) chk(rdp(k) == m[k], req, rdp(k), m[k]);
  endtask

  task automatic wr(input logic [3:0] sel, input logic [15:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic model(input logic e, input logic [7:0] p);
    int a, b;
    logic [15:0] t;
    a = slot(p[7:4]); b = slot(p[3:0]);
    if (a >= 0 && b >= 0) begin
      t = m[a];
      if (e) begin m[a] = m[b]; m[b] = t; end
      else m[b] = t;
    end
  endtask

  task automatic run(input logic e, input logic [7:0] p, input int inj, output int n);
    @(negedge clk); start = 1; op_exg = e; post = p;
    @(negedge clk); start = 0; n = 0;
    while (busy && n < 20) begin
      n++;
      start = (n == inj); post = 8'h21; op_exg = 0;
      @(negedge clk);
      start = 0;
    end
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1", {busy, done}, 0);
    for (int k = 0; k < 6; k++) m[k] = 0;
    chk_all("R1");
    rst_n = 1;

    // R9 preload through the write port
    wr(4'd1, 16'h1122); wr(4'd2, 16'h3344); wr(4'd3, 16'h5566);
    wr(4'd4, 16'h7788); wr(4'd6, 16'h99AA);
    wr(4'd8, 16'h00AB); wr(4'd9, 16'h00CD);
    m[0] = 16'hABCD; m[1] = 16'h1122; m[2] = 16'h3344; m[3] = 16'h5566;
    m[4] = 16'h7788; m[5] = 16'h99AA;
    chk_all("R9");

    // R2 R3 R5 R10 vector table
    for (int v = 0; v < NV; v++) begin
      logic e; logic [7:0] p;
      e = VEC[v][8]; p = VEC[v][7:0];
      run(e, p, 0, n);
      model(e, p);
      chk(n == (e ? 8 : 6), e ? "R3 length" : "R2 length", n, e ? 8 : 6);
      chk(done == 1, "R7 done", done, 1);
      chk_all((slot(p[7:4]) < 0 || slot(p[3:0]) < 0) ? "R5" : (e ? "R3" : "R2"));
      @(negedge clk);
      chk(done == 0, "R7 single pulse", done, 0);
    end

    // R8 direct window base
    chk(dp_base == {m[5][15:8], 8'h00}, "R8", dp_base, {m[5][15:8], 8'h00});
    wr(4'd6, 16'h4D01); m[5] = 16'h4D01;
    chk(dp_base == 16'h4D00, "R8", dp_base, 16'h4D00);

    // R4 low byte first
    wr(4'd1, 16'hA1B2); wr(4'd2, 16'hC3D4);
    @(negedge clk); start = 1; op_exg = 0; post = 8'h12;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    chk(rd_y == 16'hC3B2, "R4", rd_y, 16'hC3B2);
    @(negedge clk);
    chk(rd_y == 16'hA1B2 && done, "R4", rd_y, 16'hA1B2);
    m[1] = 16'hA1B2; m[2] = 16'hA1B2;

    // R6 start during busy ignored
    wr(4'd3, 16'h0F0F); m[3] = 16'h0F0F;
    run(1'b1, 8'h31, 3, n);
    model(1'b1, 8'h31);
    chk(n == 8, "R6 length", n, 8);
    chk_all("R6");

    // R9 write ignored while busy
    @(negedge clk); start = 1; op_exg = 0; post = 8'hFF;
    @(negedge clk); start = 0;
    wr_en = 1; wr_sel = 4'd4; wr_data = 16'hDEAD;
    @(negedge clk); wr_en = 0;
    repeat (6) @(negedge clk);
    chk(rd_s == m[4], "R9 busy write", rd_s, m[4]);

    // R9 write with start in same cycle ignored
    @(negedge clk); start = 1; op_exg = 0; post = 8'hFF;
    wr_en = 1; wr_sel = 4'd1; wr_data = 16'hBEEF;
    @(negedge clk); start = 0; wr_en = 0;
    repeat (7) @(negedge clk);
    chk(rd_x == m[1], "R9 start write", rd_x, m[1]);

    // R1 reset mid-sequence
    @(negedge clk); start = 1; op_exg = 1; post = 8'h12;
    @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    @(negedge clk); rst_n = 1;
    for (int k = 0; k < 6; k++) m[k] = 0;
    chk(busy == 0 && done == 0, "R1 mid reset", {busy, done}, 0);
    chk_all("R1");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule